// File: doc/BRIEF.md
# Branch Control-Hazard Fetch Controller

This block steers instruction fetch around branches in a five-stage in-order pipeline. The predecode logic in fetch flags a branch and supplies its target address in the same cycle the branch is fetched. The outcome arrives from decode one cycle later. A run-time mode input selects one of five ways to handle the gap between fetch and resolution: freezing fetch, static not-taken, static taken, a one-bit dynamic predictor, or a single architectural delay slot. Because the target is known at fetch and the outcome at decode, every policy pays a penalty of either zero cycles or one cycle per branch.

The block owns the fetch PC. It raises a fetch-stall flag when the word presented in fetch is not a real instruction. It raises a squash flag when the instruction now sitting in decode was fetched down the wrong path and must travel on as a bubble. A downstream stall input freezes the whole block. Two event counters, for resolved branches and for squashes, let a test compare measured cycle counts against the penalty expected for each mode.

The controller is a five-state machine that tracks what sits in decode:

- IDLE: no unresolved branch in decode.
- FROZEN: a branch is in decode and fetch is idle.
- SPEC: a branch is in decode and fetch follows a static guess.
- LEARN: a branch is in decode and fetch follows the one-bit table's guess.
- SLOT: a branch is in decode and fetch is reading its delay slot.

Transitions:

- IDLE to FROZEN, SPEC, LEARN or SLOT: a branch is fetched, and the current mode picks the state.
- FROZEN to IDLE and SLOT to IDLE: on resolution.
- SPEC to IDLE and LEARN to IDLE: on a miss, or on a hit when fetch holds no branch.
- SPEC to SPEC and LEARN to LEARN (or to another branch state): on a hit when the word fetched in that cycle is itself a branch.

Top module: `bhc_fetch_ctrl`

## Requirements
- R1: While reset is low and after it is released, the fetch PC equals RESET_PC (default 0), fetch-stall and squash are low, and both counters read zero.
- R2: The mode input encodes 0 as freeze, 1 as predict-not-taken, 2 as predict-taken, 3 as one-bit predictor and 4 as delay slot. The values 5, 6 and 7 behave exactly like freeze.
- R3: In freeze mode the cycle after a branch is fetched shows fetch-stall high with the PC held. The next cycle fetches the target if the branch was taken, or branch+4 if not. This costs one cycle per branch and causes no squash.
- R4: In predict-not-taken mode fetch continues at branch+4. A taken outcome squashes that one instruction and fetches the target next, costing one cycle per taken branch.
- R5: In predict-taken mode fetch reads the target in the cycle after the branch. A not-taken outcome squashes that one instruction and fetches branch+4 next.
- R6: In one-bit mode the guess comes from a table of 2^IDXW single-bit entries indexed by PC bits [IDXW+1:2] of the branch (1 means taken). At resolution the entry is overwritten with the actual outcome, so the cost is one cycle per change of outcome.
- R7: Every one-bit entry is set to the value of pred_init_i on reset. A first outcome that differs from that value costs one extra squashed cycle.
- R8: In delay-slot mode the word at branch+4 is always fetched and never squashed, and its branch flag is ignored. The following fetch is the target if the branch was taken, or branch+8 if not.
- R9: A misprediction raises squash_o for the one cycle in which the wrongly fetched instruction is in decode. That instruction is never treated as a branch. Squash pulses never occur back to back.
- R10: While stall_i is high, the PC, the state, the squash and fetch-stall outputs, the predictor table and both counters hold. A redirect waiting in decode takes effect on the first unstalled cycle.
- R11: br_count_o increments once per resolved branch and miss_count_o once per squash, each on the edge that ends the resolution cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Hazard policy select (see R2) |
| pred_init_i | input | 1 | Reset value of every one-bit predictor entry |
| stall_i | input | 1 | Downstream stall, freezes the block |
| if_is_br_i | input | 1 | Predecode: word at fetch_pc_o is a branch |
| if_target_i | input | AW | Predecode: target of that branch |
| id_taken_i | input | 1 | Outcome of the branch currently in decode |
| fetch_pc_o | output | AW | Address being fetched this cycle |
| fetch_stall_o | output | 1 | Fetch word this cycle is not an instruction |
| squash_o | output | 1 | Instruction in decode becomes a bubble |
| br_count_o | output | CW | Resolved-branch counter |
| miss_count_o | output | CW | Squash counter |

## Verification
The bench runs a one-branch loop of one to three instructions, taken K-1 times and then falling through. It sweeps K, the loop length, every mode value, both predictor reset values, and runs with and without periodic stalls. For each run it derives the fetch-cycle count, squash count and counter values from the per-mode penalty formula. A one-instruction loop, where the branch is its own target, catches designs that let a squashed or speculative copy of the branch resolve again; such a design would show extra resolutions and shifted cycle counts. A single-iteration loop with the predictor reset to taken exposes a table that ignores pred_init_i. Stall pulses landing on resolution cycles expose a redirect that leaks through a stall, which shows up as a moved PC or a lost cycle.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

    typedef enum logic [2:0] {
        POL_FREEZE    = 3'd0,
        POL_NOT_TAKEN = 3'd1,
        POL_TAKEN     = 3'd2,
        POL_ONEBIT    = 3'd3,
        POL_DELAY     = 3'd4
    } policy_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FROZEN,
        ST_SPEC,
        ST_LEARN,
        ST_SLOT
    } fstate_e;

    // Unused encodings fall back to the freeze policy.
    function automatic policy_e decode_mode(input logic [2:0] raw);
        policy_e pol;
        unique case (raw)
            3'd1:    pol = POL_NOT_TAKEN;
            3'd2:    pol = POL_TAKEN;
            3'd3:    pol = POL_ONEBIT;
            3'd4:    pol = POL_DELAY;
            default: pol = POL_FREEZE;
        endcase
        return pol;
    endfunction

endpackage

// File: rtl/bhc_pred_table.sv
module bhc_pred_table #(
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            init_i,
    input  logic [IDXW-1:0] rd_idx_i,
    output logic            rd_bit_o,
    input  logic            wr_en_i,
    input  logic [IDXW-1:0] wr_idx_i,
    input  logic            wr_bit_i
);
    localparam int DEPTH = 1 << IDXW;

    logic [DEPTH-1:0] bits_q;

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits_q[e] <= init_i;
            end else if (wr_en_i && (wr_idx_i == IDXW'(e))) begin
                bits_q[e] <= wr_bit_i;
            end
        end
    end

    assign rd_bit_o = bits_q[rd_idx_i];

endmodule

// File: rtl/bhc_ctr.sv
module bhc_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] ONE = W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (inc_i) begin
            cnt_o <= cnt_o + ONE;
        end
    end

endmodule

// File: rtl/bhc_seq.sv
module bhc_seq
    import bhc_pkg::*;
#(
    parameter int              AW       = 32,
    parameter int              IDXW     = 4,
    parameter logic [AW-1:0]   RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall_i,
    input  policy_e         pol_i,
    input  logic            if_is_br_i,
    input  logic [AW-1:0]   if_target_i,
    input  logic            id_taken_i,
    input  logic            pred_bit_i,
    output logic [IDXW-1:0] pred_rd_idx_o,
    output logic            pred_wr_en_o,
    output logic [IDXW-1:0] pred_wr_idx_o,
    output logic            pred_wr_bit_o,
    output logic [AW-1:0]   pc_o,
    output logic            fetch_stall_o,
    output logic            squash_o,
    output logic            resolve_o,
    output logic            mispredict_o
);
    localparam logic [AW-1:0] WORD = AW'(4);
    localparam logic [AW-1:0] PAIR = AW'(8);

    fstate_e       state_q, state_n;
    logic [AW-1:0] pc_q, pc_n;
    logic [AW-1:0] br_pc_q, br_tgt_q;
    logic          pred_q, pred_n;
    logic          squash_q, squash_n;

    fstate_e       go_state;
    logic [AW-1:0] go_pc;
    logic          go_pred;
    logic [AW-1:0] fix_pc;
    logic          resolving, missed, learning;

    // What to do with the word fetched this cycle, if it is kept.
    always_comb begin : launch
        go_state = ST_IDLE;
        go_pc    = pc_q + WORD;
        go_pred  = 1'b0;
        if (if_is_br_i) begin
            unique case (pol_i)
                POL_NOT_TAKEN: begin
                    go_state = ST_SPEC;
                end
                POL_TAKEN: begin
                    go_state = ST_SPEC;
                    go_pc    = if_target_i;
                    go_pred  = 1'b1;
                end
                POL_ONEBIT: begin
                    go_state = ST_LEARN;
                    go_pred  = pred_bit_i;
                    if (pred_bit_i) begin
                        go_pc = if_target_i;
                    end
                end
                POL_DELAY: begin
                    go_state = ST_SLOT;
                end
                default: begin
                    go_state = ST_FROZEN;
                    go_pc    = pc_q;
                end
            endcase
        end
    end

    assign fix_pc = id_taken_i ? br_tgt_q : (br_pc_q + WORD);

    // Next state: resolution of the branch in decode overrides fetch.
    always_comb begin : advance
        state_n   = go_state;
        pc_n      = go_pc;
        pred_n    = go_pred;
        squash_n  = 1'b0;
        resolving = 1'b0;
        missed    = 1'b0;
        learning  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_FROZEN: begin
                resolving = 1'b1;
                state_n   = ST_IDLE;
                pc_n      = fix_pc;
                pred_n    = 1'b0;
            end
            ST_SPEC, ST_LEARN: begin
                resolving = 1'b1;
                learning  = (state_q == ST_LEARN);
                if (id_taken_i != pred_q) begin
                    missed   = 1'b1;
                    squash_n = 1'b1;
                    state_n  = ST_IDLE;
                    pc_n     = fix_pc;
                    pred_n   = 1'b0;
                end
            end
            ST_SLOT: begin
                resolving = 1'b1;
                state_n   = ST_IDLE;
                pc_n      = id_taken_i ? br_tgt_q : (br_pc_q + PAIR);
                pred_n    = 1'b0;
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pc_q     <= RESET_PC;
            br_pc_q  <= '0;
            br_tgt_q <= '0;
            pred_q   <= 1'b0;
            squash_q <= 1'b0;
        end else if (!stall_i) begin
            state_q  <= state_n;
            pc_q     <= pc_n;
            pred_q   <= pred_n;
            squash_q <= squash_n;
            if (state_n != ST_IDLE) begin
                br_pc_q  <= pc_q;
                br_tgt_q <= if_target_i;
            end
        end
    end

    // Outputs.
    always_comb begin : drive
        pc_o          = pc_q;
        fetch_stall_o = (state_q == ST_FROZEN);
        squash_o      = squash_q;
        resolve_o     = resolving & ~stall_i;
        mispredict_o  = missed & ~stall_i;
        pred_wr_en_o  = learning & ~stall_i;
        pred_wr_idx_o = br_pc_q[IDXW+1:2];
        pred_wr_bit_o = id_taken_i;
        pred_rd_idx_o = pc_q[IDXW+1:2];
    end

endmodule

// File: rtl/bhc_fetch_ctrl.sv
module bhc_fetch_ctrl
    import bhc_pkg::*;
#(
    parameter int            AW       = 32,
    parameter int            IDXW     = 4,
    parameter int            CW       = 16,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode_i,
    input  logic          pred_init_i,
    input  logic          stall_i,
    input  logic          if_is_br_i,
    input  logic [AW-1:0] if_target_i,
    input  logic          id_taken_i,
    output logic [AW-1:0] fetch_pc_o,
    output logic          fetch_stall_o,
    output logic          squash_o,
    output logic [CW-1:0] br_count_o,
    output logic [CW-1:0] miss_count_o
);
    localparam int NCTR = 2;

    policy_e         pol;
    logic            pred_bit;
    logic [IDXW-1:0] rd_idx, wr_idx;
    logic            wr_en, wr_bit;
    logic            resolve, mispredict;
    logic [NCTR-1:0] ctr_inc;
    logic [CW-1:0]   ctr_val [NCTR];

    assign pol = decode_mode(mode_i);

    bhc_seq #(
        .AW(AW), .IDXW(IDXW), .RESET_PC(RESET_PC)
    ) seq_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .stall_i       (stall_i),
        .pol_i         (pol),
        .if_is_br_i    (if_is_br_i),
        .if_target_i   (if_target_i),
        .id_taken_i    (id_taken_i),
        .pred_bit_i    (pred_bit),
        .pred_rd_idx_o (rd_idx),
        .pred_wr_en_o  (wr_en),
        .pred_wr_idx_o (wr_idx),
        .pred_wr_bit_o (wr_bit),
        .pc_o          (fetch_pc_o),
        .fetch_stall_o (fetch_stall_o),
        .squash_o      (squash_o),
        .resolve_o     (resolve),
        .mispredict_o  (mispredict)
    );

    bhc_pred_table #(.IDXW(IDXW)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (pred_init_i),
        .rd_idx_i (rd_idx),
        .rd_bit_o (pred_bit),
        .wr_en_i  (wr_en),
        .wr_idx_i (wr_idx),
        .wr_bit_i (wr_bit)
    );

    assign ctr_inc = {mispredict, resolve};

    for (genvar c = 0; c < NCTR; c++) begin : g_ctr
        bhc_ctr #(.W(CW)) ctr_i (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (ctr_inc[c]),
            .cnt_o (ctr_val[c])
        );
    end

    assign br_count_o   = ctr_val[0];
    assign miss_count_o = ctr_val[1];

endmodule

// File: rtl/bhc_fetch_ctrl_chk.sv
module bhc_fetch_ctrl_chk #(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stall_i,
    input logic [AW-1:0] fetch_pc_o,
    input logic          fetch_stall_o,
    input logic          squash_o,
    input logic [CW-1:0] br_count_o,
    input logic [CW-1:0] miss_count_o
);
    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> ($stable(fetch_pc_o) && $stable(squash_o) && $stable(fetch_stall_o)
                     && $stable(br_count_o) && $stable(miss_count_o)));

    // R3
    one_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_stall_o && !stall_i) |=> !fetch_stall_o);

    // R9
    lone_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_o && !stall_i) |=> !squash_o);

    // R3
    freeze_no_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(squash_o && fetch_stall_o));

    // R11
    miss_tracks_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(miss_count_o) |-> squash_o);

endmodule

bind bhc_fetch_ctrl bhc_fetch_ctrl_chk #(.AW(AW), .CW(CW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall_i       (stall_i),
    .fetch_pc_o    (fetch_pc_o),
    .fetch_stall_o (fetch_stall_o),
    .squash_o      (squash_o),
    .br_count_o    (br_count_o),
    .miss_count_o  (miss_count_o)
);

// File: tb/bhc_fetch_ctrl_tb_top.sv
`timescale 1ns/1ps
module bhc_fetch_ctrl_tb_top;
    localparam int AW = 32;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode_i = '0;
    logic          pred_init_i = 1'b0;
    logic          stall_i = 1'b0;
    logic          if_is_br_i;
    logic [AW-1:0] if_target_i;
    logic          id_taken_i = 1'b0;
    logic [AW-1:0] fetch_pc_o;
    logic          fetch_stall_o;
    logic          squash_o;
    logic [CW-1:0] br_count_o;
    logic [CW-1:0] miss_count_o;

    logic [AW-1:0] br_addr = '0;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    // Program: a single backward branch at br_addr targeting address 0.
    assign if_is_br_i  = (fetch_pc_o == br_addr);
    assign if_target_i = '0;

    bhc_fetch_ctrl #(.AW(AW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pred_init_i(pred_init_i),
        .stall_i(stall_i), .if_is_br_i(if_is_br_i), .if_target_i(if_target_i),
        .id_taken_i(id_taken_i), .fetch_pc_o(fetch_pc_o),
        .fetch_stall_o(fetch_stall_o), .squash_o(squash_o),
        .br_count_o(br_count_o), .miss_count_o(miss_count_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string mode_tag(input int m);
        case (m)
            1:       return "R4";
            2:       return "R5";
            3:       return "R6";
            4:       return "R8";
            0:       return "R3";
            default: return "R2";
        endcase
    endfunction

    task automatic run(input int m, input bit init, input int k, input int l, input bit stl);
        logic [AW-1:0] prev_pc;
        logic [AW-1:0] hold_pc;
        bit  prev_fs, dec_br, done, hold_chk, o, pv;
        int  nres, cyc, nsq, step, guard, exp_cyc, exp_mis, base, tr;

        mode_i      = 3'(m);
        pred_init_i = init;
        br_addr     = AW'(4 * (l - 1));
        stall_i     = 1'b0;
        rst_n       = 1'b0;
        repeat (2) @(negedge clk);
        // R1: reset state
        check(fetch_pc_o == '0 && !fetch_stall_o && !squash_o &&
              br_count_o == '0 && miss_count_o == '0,
              "R1", "reset state pc", longint'(fetch_pc_o), 0);
        rst_n = 1'b1;

        // Expected penalties from the per-mode rules.
        base = k * l + 1;
        tr = 0; pv = init;
        for (int i = 0; i < k; i++) begin
            o = (i < k - 1);
            if (o != pv) tr++;
            pv = o;
        end
        case (m)
            1:       begin exp_cyc = base + (k - 1); exp_mis = k - 1; end
            2:       begin exp_cyc = base + 1;       exp_mis = 1;     end
            3:       begin exp_cyc = base + tr;      exp_mis = tr;    end
            4:       begin exp_cyc = k * (l + 1);    exp_mis = 0;     end
            default: begin exp_cyc = base + k;       exp_mis = 0;     end
        endcase

        prev_pc = '0; prev_fs = 1'b1; nres = 0; cyc = 0; nsq = 0;
        step = 0; done = 1'b0; guard = 0; hold_pc = '0;
        while (!done && guard < 400) begin
            guard++;
            if (fetch_pc_o == br_addr + AW'(8)) begin
                done = 1'b1;
            end else begin
                dec_br     = !prev_fs && !squash_o && (prev_pc == br_addr);
                id_taken_i = (nres < k - 1);
                stall_i    = stl && (step % 3 == 1);
                step++;
                hold_chk   = stall_i;
                hold_pc    = fetch_pc_o;
                if (!stall_i) begin
                    if (squash_o) nsq++;
                    if (dec_br) nres++;
                    prev_pc = fetch_pc_o;
                    prev_fs = fetch_stall_o;
                    cyc++;
                end
                @(negedge clk);
                if (hold_chk) begin
                    // R10: a stalled cycle leaves the PC unchanged
                    check(fetch_pc_o == hold_pc, "R10", "pc under stall",
                          longint'(fetch_pc_o), longint'(hold_pc));
                end
            end
        end
        stall_i = 1'b0;
        check(done, mode_tag(m), "loop exit reached", longint'(done), 1);
        check(cyc == exp_cyc, mode_tag(m), "fetch cycles", cyc, exp_cyc);
        // R11: counters
        check(br_count_o == CW'(k), "R11", "branch count", longint'(br_count_o), k);
        check(miss_count_o == CW'(exp_mis), "R11", "miss count",
              longint'(miss_count_o), exp_mis);
        // R9: one squash pulse per miss
        check(nsq == exp_mis, "R9", "squash pulses", nsq, exp_mis);
        if (m == 3) begin
            // R7: initial predictor value shapes the miss count
            check(nsq == exp_mis, "R7", "one-bit misses from init", nsq, exp_mis);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        for (int m = 0; m < 8; m++) begin
            for (int ini = 0; ini < 2; ini++) begin
                for (int ki = 0; ki < 4; ki++) begin
                    for (int l = 1; l <= 3; l++) begin
                        for (int s = 0; s < 2; s++) begin
                            int k;
                            k = (ki == 3) ? 5 : ki + 1;
                            if (m < 5 || (ini == 0 && s == 0))
                                run(m, 1'(ini), k, l, 1'(s));
                        end
                    end
                end
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule